// File: doc/BRIEF.md
# Multiplexed ADC Conversion Sequencer

This block runs single conversions on an eight-input successive-approximation converter for a client that only wants to name an input and receive a byte back. The client raises a request with a 3-bit input number while the sequencer is idle. The sequencer puts that number on the converter's command lines for one cycle of setup. It then sets the start strobe for exactly one cycle and polls the end-of-conversion line every cycle. When it finds that line high, it enables the converter's output for one cycle, latches the byte, and returns it with a one-cycle valid strobe.

The command word sent to the converter is four bits wide. Bits 2..0 carry the input number, and bit 3 is the start strobe, so input 5 with the strobe set reads 0xD. A programmable limit bounds the polling. If end-of-conversion stays low for more cycles than the limit allows, the sequencer gives up, pulses an error flag and returns to idle. While a conversion is in flight the block reports busy and ignores requests.

Top module: `adc_conv_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, `busy`, `adc_cmd`, `adc_oe`, `rsp_valid` and `rsp_err` are all zero.
- R2: A request seen while idle is accepted. In the next cycle `adc_cmd[2:0]` equals the requested input, `adc_cmd[3]` is low, and `busy` is high.
- R3: The start strobe `adc_cmd[3]` is high for exactly one cycle, the second cycle after acceptance. The input number does not change across its rising edge.
- R4: `adc_cmd[2:0]` holds the accepted input for the whole conversion and keeps it until the next request is accepted.
- R5: After the strobe, `adc_eoc` is sampled once per cycle. `adc_oe` is high for exactly one cycle, the cycle after `adc_eoc` was first seen high, and never goes high without that.
- R6: `rsp_valid` pulses for one cycle right after the `adc_oe` cycle. `rsp_data` then equals the byte on `adc_data` during the `adc_oe` cycle, and `rsp_chan` equals the accepted input.
- R7: If `adc_eoc` is low in each of `tmo_limit`+1 consecutive polling cycles, `rsp_err` pulses for one cycle, no `rsp_valid` follows, and the block returns to idle. `rsp_valid` and `rsp_err` are never high together.
- R8: If `adc_eoc` is first seen high in the polling cycle where the limit is reached (the (`tmo_limit`+1)-th poll), the result is returned and no error is raised.
- R9: A request made while `busy` is high has no effect. The input number, the strobe and the response stay as they would be without it.
- R10: A request present in the cycle where `rsp_valid` or `rsp_err` is high is accepted, because `busy` is already low then.
- R11: With `tmo_limit` = 0, exactly one poll is made: the result is returned if `adc_eoc` is high on that poll, and an error is raised otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Conversion request |
| req_chan | input | 3 | Requested input number |
| busy | output | 1 | Conversion in flight; requests ignored |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_data | output | 8 | Converted byte |
| rsp_chan | output | 3 | Input number of the returned result |
| rsp_err | output | 1 | One-cycle timeout strobe |
| tmo_limit | input | 16 | Polling limit, in cycles |
| adc_cmd | output | 4 | Converter command: [2:0] input, [3] start strobe |
| adc_eoc | input | 1 | End of conversion from converter |
| adc_oe | output | 1 | Converter output enable |
| adc_data | input | 8 | Converter result bus |

## Verification
Two of the block's functions can fall in the same cycle. The first pair is end-of-conversion detection and timeout expiry, when EOC rises on the very poll where the limit runs out. The bench provokes this by setting the modelled converter's latency to exactly the limit plus one, and also one cycle beyond it, so that the result and the error land on either side of the boundary. The second pair is response delivery and acceptance of a new request. The bench holds a request high across a whole conversion and judges, against its cycle-by-cycle model, that the request is ignored while busy and taken in the response cycle.

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int CH_W   = 3,
  parameter int DATA_W = 8,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CH_W-1:0]   req_chan,
  output logic              busy,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [CH_W-1:0]   rsp_chan,
  output logic              rsp_err,
  input  logic [TMO_W-1:0]  tmo_limit,
  output logic [CH_W:0]     adc_cmd,
  input  logic              adc_eoc,
  output logic              adc_oe,
  input  logic [DATA_W-1:0] adc_data
);
  localparam int SOC_BIT = CH_W;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_START, S_WAIT, S_READ} st_t;

  st_t              st;
  logic [CH_W-1:0]  chan_q;
  logic [TMO_W-1:0] poll_cnt;

  assign busy    = (st != S_IDLE);
  assign adc_oe  = (st == S_READ);
  assign adc_cmd = {st == S_START, chan_q};
  assign rsp_chan = chan_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      chan_q    <= '0;
      poll_cnt  <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          chan_q <= req_chan;
          st     <= S_SETUP;
        end
        S_SETUP: st <= S_START;
        S_START: begin
          poll_cnt <= '0;
          st       <= S_WAIT;
        end
        S_WAIT: begin
          if (adc_eoc) begin
            st <= S_READ;
          end else if (poll_cnt == tmo_limit) begin
            rsp_err <= 1'b1;
            st      <= S_IDLE;
          end else begin
            poll_cnt <= poll_cnt + 1'b1;
          end
        end
        S_READ: begin
          rsp_data  <= adc_data;
          rsp_valid <= 1'b1;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_SOC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cmd[SOC_BIT] |=> !adc_cmd[SOC_BIT]); // R3
  AST_CHAN_BEFORE_SOC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_cmd[SOC_BIT]) |-> $stable(adc_cmd[CH_W-1:0])); // R3
  AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(adc_cmd[CH_W-1:0])); // R4
  AST_OE_NEEDS_EOC: assert property (@(posedge clk) disable iff (!rst_n)
    adc_oe |-> $past(adc_eoc)); // R5
  AST_OE_THEN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    adc_oe |=> (!adc_oe && rsp_valid)); // R6
  AST_NO_VALID_AND_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && rsp_err)); // R7
  AST_IDLE_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> !busy); // R7
endmodule

// File: tb/tb_adc_conv_seq.sv
module tb_adc_conv_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_chan = '0;
  logic busy, rsp_valid, rsp_err, adc_oe;
  logic [7:0] rsp_data;
  logic [2:0] rsp_chan;
  logic [15:0] tmo_limit = 16'd20;
  logic [3:0] adc_cmd;
  logic adc_eoc = 1'b0;
  logic [7:0] adc_data;

  always #10 clk = ~clk;

  adc_conv_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_chan(rsp_chan),
    .rsp_err(rsp_err), .tmo_limit(tmo_limit), .adc_cmd(adc_cmd),
    .adc_eoc(adc_eoc), .adc_oe(adc_oe), .adc_data(adc_data)
  );

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  // converter model: latency -1 means EOC never rises
  int lat = 4;
  int cd = -1;
  logic [7:0] conv_val = 8'h00;
  logic [7:0] seed = 8'h3C;
  assign adc_data = adc_oe ? conv_val : 8'hA5;

  always @(negedge clk) begin
    if (rst_n && adc_cmd[3]) begin
      adc_eoc <= 1'b0;
      seed = seed * 8'd37 + 8'd11;
      conv_val <= {adc_cmd[2:0], seed[4:0]};
      cd = lat;
      if (lat == 0) adc_eoc <= 1'b1;
    end else if (cd > 0) begin
      cd = cd - 1;
      if (cd == 0) adc_eoc <= 1'b1;
    end
  end

  // reference model: phase 0 idle, 1 setup, 2 strobe, 3 polling, 4 read, then response
  int ph = 0;
  int polls = 0;
  int m_ch = 0;
  bit m_valid = 0, m_err = 0;
  int m_data = 0;
  int last_data = 0;
  int n_valid = 0, n_err = 0;

  always @(posedge clk) begin
    m_valid = 0; m_err = 0;
    if (!rst_n) begin
      ph = 0; m_ch = 0; m_data = 0;
    end else begin
      case (ph)
        0: if (req_valid) begin m_ch = int'(req_chan); ph = 1; end
        1: ph = 2;
        2: begin ph = 3; polls = 0; end
        3: if (adc_eoc) ph = 4;
           else if (polls == int'(tmo_limit)) begin m_err = 1; ph = 0; end
           else polls++;
        4: begin m_valid = 1; m_data = last_data; ph = 0; end
        default: ph = 0;
      endcase
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", rq, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (ph == 4) last_data = int'(adc_data);
    if (rst_n) begin
      if (rsp_valid) n_valid++;
      if (rsp_err) n_err++;
      chk(busy == (ph != 0), "R9 busy", busy, ph != 0);
      chk(int'(adc_cmd[2:0]) == m_ch, "R4 channel", adc_cmd[2:0], m_ch);
      chk(adc_cmd[3] == (ph == 2), "R3 strobe", adc_cmd[3], ph == 2);
      chk(adc_oe == (ph == 4), "R5 output enable", adc_oe, ph == 4);
      chk(rsp_valid == m_valid, "R6 valid", rsp_valid, m_valid);
      chk(rsp_err == m_err, "R7 error", rsp_err, m_err);
      if (m_valid) begin
        chk(int'(rsp_data) == m_data, "R6 data", rsp_data, m_data);
        chk(int'(rsp_chan) == m_ch, "R6 chan", rsp_chan, m_ch);
      end
    end
  end

  task automatic request(input int ch);
    @(negedge clk); req_valid = 1'b1; req_chan = 3'(ch);
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic finish_one(output bit got_v, output bit got_e);
    int v0, e0;
    v0 = n_valid; e0 = n_err;
    got_v = 0; got_e = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (n_valid != v0 || n_err != e0) break;
    end
    got_v = (n_valid != v0); got_e = (n_err != e0);
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit v, e;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({busy, adc_cmd, adc_oe, rsp_valid, rsp_err} == '0, "R1 reset", {busy, adc_cmd, adc_oe, rsp_valid, rsp_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, adc_cmd, adc_oe, rsp_valid, rsp_err} == '0, "R1 after reset", {busy, adc_cmd, adc_oe, rsp_valid, rsp_err}, 0);

    // R2 R3 R5 R6: every input, varied latency
    for (int c = 0; c < 8; c++) begin
      lat = 2 + c;
      @(negedge clk); req_valid = 1'b1; req_chan = 3'(c);
      @(negedge clk); req_valid = 1'b0;
      chk(busy && adc_cmd == {1'b0, 3'(c)}, "R2 setup", adc_cmd, c);
      @(negedge clk);
      chk(adc_cmd == {1'b1, 3'(c)}, "R3 strobe word", adc_cmd, 8 + c);
      finish_one(v, e);
      chk(v && !e, "R6 result", v, 1);
    end

    // R9: requests while busy
    lat = 8;
    request(2);
    repeat (3) begin
      @(negedge clk); req_valid = 1'b1; req_chan = 3'd6;
    end
    @(negedge clk); req_valid = 1'b0;
    finish_one(v, e);
    chk(v && int'(rsp_chan) == 2, "R9 ignored", rsp_chan, 2);

    // R7: EOC never rises
    tmo_limit = 16'd5; lat = -1;
    request(3);
    finish_one(v, e);
    chk(e && !v, "R7 timeout", {v, e}, 1);

    // R8: EOC on the last allowed poll, and one poll late
    lat = 6;
    request(4);
    finish_one(v, e);
    chk(v && !e, "R8 edge result", {v, e}, 2);
    lat = 7;
    request(5);
    finish_one(v, e);
    chk(e && !v, "R7 one late", {v, e}, 1);

    // R11: limit zero
    tmo_limit = 16'd0; lat = 1;
    request(1);
    finish_one(v, e);
    chk(v && !e, "R11 single poll hit", {v, e}, 2);
    lat = 2;
    request(1);
    finish_one(v, e);
    chk(e && !v, "R11 single poll miss", {v, e}, 1);

    // R10: request held high, accepted in response cycle
    tmo_limit = 16'd20; lat = 3;
    @(negedge clk); req_valid = 1'b1; req_chan = 3'd7;
    for (int i = 0; i < 40; i++) @(negedge clk);
    req_valid = 1'b0;
    finish_one(v, e);
    chk(n_valid >= 13, "R10 back to back", n_valid, 13);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule